// File: doc/BRIEF.md
# SMBus Burst Byte Queue with Threshold Flags

This block sits between a byte-wide register port and a byte-level SMBus shifter. Software can then queue up to sixteen outgoing bytes, or collect up to sixteen incoming bytes, per burst instead of servicing one byte at a time. A queue-enable bit turns the mode on. When it is off, the queues are flushed and held empty, and the data register has no effect.

Each direction has a threshold field, an interrupt enable and a sticky threshold-reached flag. Two further sticky flags are shared. One records that a burst has finished: the transmit queue has drained, or the last expected receive byte has arrived. The other records that a byte was dropped because its queue was full. A single interrupt line combines the flags with their enables. A bank-select bit in a shared register switches the upper part of the register map between the enable register (bank 0) and the queue control and status registers (bank 1). The byte-ready status bit is held low while software waits on the receive threshold interrupt.

Register accesses are single-cycle: a write takes effect at the clock edge where `regWr` is high. Read data is combinational from `regAddr`. A read of the data register pops the receive queue at that edge.

Top module: `byte_burst_fifo`

## Requirements
- R1: After reset the queue enable, the bank select and all flags are 0, both byte counts are 0, and `irq`, `byteReady` and `txValid` are low.
- R2: The enable bit is bit 4 of address 3 in bank 0 and reads back as written. While it is 0, data register writes are ignored: `txValid` stays low and the transmit count (bit positions 4:0 of address 5, bank 1) stays 0.
- R3: With the queue on, a write to address 0 pushes a byte. The bytes leave on `txByte`, in order, one per cycle in which `txValid` and `txReady` are both high. A write while 16 bytes are queued is dropped and sets the sticky overflow bit (bit 0 of address 3, bank 1, write 1 to clear).
- R4: Writing 1 to bit 6 of address 3 in bank 1 flushes both queues and clears all flags. That bit reads 0 afterwards, while bit 3 (burst-done interrupt enable) reads back as written.
- R5: The transmit control register (address 4, bank 1) holds an interrupt enable at bit 6 and a threshold at bits 4:0. When a pop leaves the transmit count equal to the threshold, bit 6 of address 5 sets. Writing 1 to that bit clears it.
- R6: The burst-done flag is bit 1 of address 3 in bank 1. It sets when a pop empties the transmit queue. Writing 1 to it clears it.
- R7: A byte presented with `rxValid` is pushed into the receive queue. Each read of address 0 returns the oldest byte and lowers the receive count (bits 4:0 of address 7, bank 1) by one. A push into a full receive queue is dropped and sets the overflow bit.
- R8: The receive control register (address 6, bank 1) holds an interrupt enable at bit 6, a last-byte marker at bit 5 and a threshold at bits 4:0. When a push brings the receive count to the threshold, bit 6 of address 7 sets. If the marker is also set, the burst-done flag sets as well.
- R9: `byteReady` (also bit 0 of address 1) is high when the receive queue holds a byte. The exception is that it stays low while the receive interrupt enable is set and fewer than 16 bytes are held.
- R10: `irq` is the OR of each flag ANDed with its enable: transmit threshold, receive threshold, and burst-done with bit 3 of address 3. It drops when a flush or a disable clears the flags.
- R11: The bank-select bit is bit 7 of address 2. In bank 0, addresses 4 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops the receive queue at address 0) |
| regWData | input | 8 | Register write data |
| regRData | output | 8 | Register read data |
| txByte | output | 8 | Oldest queued transmit byte |
| txValid | output | 1 | Transmit byte available |
| txReady | input | 1 | Shifter takes the transmit byte |
| rxByte | input | 8 | Byte from the shifter |
| rxValid | input | 1 | Shifter delivers a byte |
| irq | output | 1 | Threshold / burst interrupt |
| byteReady | output | 1 | Legacy byte-ready status |

## Verification
On every cycle, the assertions check these invariants: the queue counts never pass the depth, a full queue keeps its count, a flush empties both queues, `txValid` is low while the mode is off, `irq` is low once the mode has been off for a cycle, and `byteReady` never rises over an empty receive queue. Only the bench scenarios can show the rest. That covers byte order through both queues, where each threshold flag sets relative to the count sequence, write-one-to-clear and self-clearing bits, and the suppression of byte-ready at 1 against 16 held bytes. It also covers dropped writes seen through the counts, and the bank-0 view of the upper addresses.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
  // strobes from the control block to the datapath, one cycle each
  typedef struct packed {
    logic       txPush;
    logic [7:0] txData;
    logic       rxPush;
    logic       rxPop;
    logic       flush;
  } fifoStrobes_t;
endpackage

// File: rtl/bbf_queue.sv
module bbf_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             pushOk,
  output logic             popOk
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;

  assign full   = (count == CW'(DEPTH));
  assign pushOk = push && !full;
  assign popOk  = pop && (count != '0);
  assign head   = store[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && !pop && !flush) |=> full);
  p_flush_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
endmodule

// File: rtl/bbf_datapath.sv
module bbf_datapath
  import bbf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifoStrobes_t strobes,
  input  logic [7:0]   rxByte,
  input  logic         txReady,
  output logic [7:0]   txByte,
  output logic         txValid,
  output logic [7:0]   rxHead,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic         txFull,
  output logic         rxFull,
  output logic         txPopped,
  output logic         rxPushed
);
  logic txPushOk, rxPopOk;

  assign txValid = (txCount != '0);

  bbf_queue #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rstN(rstN), .flush(strobes.flush),
    .push(strobes.txPush), .pushData(strobes.txData),
    .pop(txReady), .head(txByte), .count(txCount), .full(txFull),
    .pushOk(txPushOk), .popOk(txPopped)
  );

  bbf_queue #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(strobes.flush),
    .push(strobes.rxPush), .pushData(rxByte),
    .pop(strobes.rxPop), .head(rxHead), .count(rxCount), .full(rxFull),
    .pushOk(rxPushed), .popOk(rxPopOk)
  );

  // the control block gates pushes and pops, so the queues never refuse one
  p_gated_push_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txPush |-> txPushOk);
  p_gated_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxPop |-> rxPopOk);
endmodule

// File: rtl/bbf_ctrl.sv
module bbf_ctrl
  import bbf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    regAddr,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [7:0]    regWData,
  output logic [7:0]    regRData,
  input  logic          rxValid,
  input  logic [7:0]    rxHead,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic          txFull,
  input  logic          rxFull,
  input  logic          txPopped,
  input  logic          rxPushed,
  output fifoStrobes_t  strobes,
  output logic          fifoEn,
  output logic          irq,
  output logic          byteReady
);
  logic       bankSel, doneIe, txIe, rxIe, rxLast;
  logic [4:0] txThr, rxThr;
  logic       txFlag, rxFlag, doneFlag, ovfFlag;
  logic       txPopSeen, rxPushSeen;

  logic wrB1, wrB0, dataWr, dataRd, clrCmd, offCmd;
  logic [4:0] txCnt5, rxCnt5;

  assign txCnt5 = 5'(txCount);
  assign rxCnt5 = 5'(rxCount);
  assign wrB1   = regWr && bankSel;
  assign wrB0   = regWr && !bankSel;
  assign dataWr = regWr && (regAddr == 3'd0);
  assign dataRd = regRd && (regAddr == 3'd0);
  assign clrCmd = wrB1 && (regAddr == 3'd3) && regWData[6];
  assign offCmd = wrB0 && (regAddr == 3'd3) && !regWData[4] && fifoEn;

  always_comb begin
    strobes        = '0;
    strobes.txPush = dataWr && fifoEn && !txFull;
    strobes.txData = regWData;
    strobes.rxPush = rxValid && fifoEn && !rxFull;
    strobes.rxPop  = dataRd && fifoEn && (rxCount != '0);
    strobes.flush  = clrCmd || offCmd;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSel <= 1'b0; fifoEn <= 1'b0; doneIe <= 1'b0;
      txIe <= 1'b0; txThr <= '0; rxIe <= 1'b0; rxLast <= 1'b0; rxThr <= '0;
    end else begin
      if (regWr && regAddr == 3'd2) bankSel <= regWData[7];
      if (wrB0 && regAddr == 3'd3) fifoEn <= regWData[4];
      if (wrB1 && regAddr == 3'd3) doneIe <= regWData[3];
      if (wrB1 && regAddr == 3'd4) begin
        txIe <= regWData[6]; txThr <= regWData[4:0];
      end
      if (wrB1 && regAddr == 3'd6) begin
        rxIe <= regWData[6]; rxLast <= regWData[5]; rxThr <= regWData[4:0];
      end
    end
  end

  // sticky flags: set events win over a same-cycle write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) begin
      txFlag <= 1'b0; rxFlag <= 1'b0; doneFlag <= 1'b0; ovfFlag <= 1'b0;
      txPopSeen <= 1'b0; rxPushSeen <= 1'b0;
    end else begin
      txPopSeen  <= txPopped;
      rxPushSeen <= rxPushed;
      if (wrB1 && regAddr == 3'd5 && regWData[6]) txFlag <= 1'b0;
      if (txPopSeen && txCnt5 == txThr) txFlag <= 1'b1;
      if (wrB1 && regAddr == 3'd7 && regWData[6]) rxFlag <= 1'b0;
      if (rxPushSeen && rxCnt5 == rxThr) rxFlag <= 1'b1;
      if (wrB1 && regAddr == 3'd3 && regWData[1]) doneFlag <= 1'b0;
      if ((txPopSeen && txCount == '0) ||
          (rxPushSeen && rxLast && rxCnt5 == rxThr)) doneFlag <= 1'b1;
      if (wrB1 && regAddr == 3'd3 && regWData[0]) ovfFlag <= 1'b0;
      if (fifoEn && ((dataWr && txFull) || (rxValid && rxFull))) ovfFlag <= 1'b1;
    end
  end

  assign irq = (txFlag && txIe) || (rxFlag && rxIe) || (doneFlag && doneIe);
  assign byteReady = fifoEn && (rxCount != '0) &&
                     !(rxIe && rxCount < CW'(DEPTH));

  always_comb begin
    regRData = '0;
    case (regAddr)
      3'd0: regRData = fifoEn ? rxHead : 8'h00;
      3'd1: regRData = {7'b0, byteReady};
      3'd2: regRData = {bankSel, 7'b0};
      3'd3: regRData = bankSel ? {4'b0, doneIe, 1'b0, doneFlag, ovfFlag}
                               : {3'b0, fifoEn, 4'b0};
      3'd4: if (bankSel) regRData = {1'b0, txIe, 1'b0, txThr};
      3'd5: if (bankSel) regRData = {1'b0, txFlag, 1'b0, txCnt5};
      3'd6: if (bankSel) regRData = {1'b0, rxIe, rxLast, rxThr};
      default: if (bankSel) regRData = {1'b0, rxFlag, 1'b0, rxCnt5};
    endcase
  end

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && $past(!fifoEn)) |-> !irq);
  p_ready_nonempty_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> (rxCount != '0));
endmodule

// File: rtl/byte_burst_fifo.sv
module byte_burst_fifo
  import bbf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWData,
  output logic [7:0] regRData,
  output logic [7:0] txByte,
  output logic       txValid,
  input  logic       txReady,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  output logic       irq,
  output logic       byteReady
);
  localparam int CW = $clog2(DEPTH) + 1;

  fifoStrobes_t  strobes;
  logic [CW-1:0] txCount, rxCount;
  logic [7:0]    rxHead;
  logic          txFull, rxFull, txPopped, rxPushed, fifoEn;

  bbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWData(regWData), .regRData(regRData), .rxValid(rxValid),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .rxFull(rxFull), .txPopped(txPopped),
    .rxPushed(rxPushed), .strobes(strobes), .fifoEn(fifoEn),
    .irq(irq), .byteReady(byteReady)
  );

  bbf_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxByte(rxByte),
    .txReady(txReady), .txByte(txByte), .txValid(txValid), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .rxFull(rxFull),
    .txPopped(txPopped), .rxPushed(rxPushed)
  );

  p_txvalid_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> !txValid);
endmodule

// File: tb/byte_burst_fifo_tb.sv
module byte_burst_fifo_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWData = '0;
  logic [7:0] regRData, txByte, rxByte = '0;
  logic       txValid, txReady = 1'b0, rxValid = 1'b0, irq, byteReady;

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;
  logic [7:0] txExp[$];
  logic [7:0] rxExp[$];
  int txModelCnt = 0;

  always #5 clk = ~clk;

  byte_burst_fifo u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWData(regWData), .regRData(regRData), .txByte(txByte),
    .txValid(txValid), .txReady(txReady), .rxByte(rxByte),
    .rxValid(rxValid), .irq(irq), .byteReady(byteReady)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    regAddr = a; regWData = d; regWr = 1'b1;
    @(posedge clk); #2;
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #2;
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    d = regRData;
    @(posedge clk); #2;
    regRd = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    regRead(a, v);
    chk(req, v, exp);
  endtask

  // driver: queues the expected byte only if the model has room
  task automatic pushTx(input logic [7:0] b);
    if (txModelCnt < 16) begin
      txExp.push_back(b);
      txModelCnt++;
    end
    regWrite(3'd0, b);
  endtask

  task automatic shiftIn(input logic [7:0] b, input bit expectKept);
    @(posedge clk); #2;
    rxByte = b; rxValid = 1'b1;
    if (expectKept) rxExp.push_back(b);
    @(posedge clk); #2;
    rxValid = 1'b0;
  endtask

  task automatic readRx();
    logic [7:0] v;
    logic [7:0] e;
    regRead(3'd0, v);
    e = (rxExp.size() > 0) ? rxExp.pop_front() : 8'hXX;
    chk("R7 rx order", v, e);
  endtask

  task automatic drainTx(input int cycles);
    @(posedge clk); #2; txReady = 1'b1;
    repeat (cycles) @(posedge clk);
    #2; txReady = 1'b0;
    txModelCnt = 0;
  endtask

  // monitor: scoreboard for the transmit side
  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      if (txExp.size() == 0) chk("R3 tx unexpected byte", txByte, 8'hXX);
      else chk("R3 tx order", txByte, txExp.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 byteReady", {7'b0, byteReady}, 8'h00);
    chk("R1 txValid", {7'b0, txValid}, 8'h00);
    readChk("R1 bank reg", 3'd2, 8'h00);
    readChk("R1 enable reg", 3'd3, 8'h00);

    // R2 disabled: data write ignored
    regWrite(3'd0, 8'h55);
    @(negedge clk);
    chk("R2 txValid while off", {7'b0, txValid}, 8'h00);
    regWrite(3'd3, 8'h10);
    readChk("R2 enable readback", 3'd3, 8'h10);

    // R11 bank select, R4 clear
    regWrite(3'd2, 8'h80);
    readChk("R11 bank readback", 3'd2, 8'h80);
    regWrite(3'd3, 8'h48);
    readChk("R4 clear self-clears", 3'd3, 8'h08);
    readChk("R4 tx count zero", 3'd5, 8'h00);
    readChk("R4 rx count zero", 3'd7, 8'h00);
    regWrite(3'd3, 8'h40);

    // R3/R5/R6 transmit burst, threshold 0
    regWrite(3'd4, 8'h40);
    pushTx(8'hA1); pushTx(8'hB2); pushTx(8'hC3);
    readChk("R3 tx count", 3'd5, 8'h03);
    chk("R10 irq idle", {7'b0, irq}, 8'h00);
    drainTx(20);
    readChk("R5 tx flag at 0", 3'd5, 8'h40);
    @(negedge clk);
    chk("R10 irq on tx flag", {7'b0, irq}, 8'h01);
    readChk("R6 done set", 3'd3, 8'h02);
    regWrite(3'd5, 8'h40);
    readChk("R5 tx flag w1c", 3'd5, 8'h00);
    @(negedge clk);
    chk("R10 irq after w1c", {7'b0, irq}, 8'h00);
    regWrite(3'd3, 8'h02);
    readChk("R6 done w1c", 3'd3, 8'h00);

    // R5 threshold 2: not reached with one byte, reached with four
    regWrite(3'd4, 8'h42);
    pushTx(8'h01);
    drainTx(10);
    readChk("R5 tx flag not reached", 3'd5, 8'h00);
    pushTx(8'h10); pushTx(8'h20); pushTx(8'h30); pushTx(8'h40);
    drainTx(20);
    readChk("R5 tx flag passed 2", 3'd5, 8'h40);
    regWrite(3'd5, 8'h40);
    regWrite(3'd3, 8'h02);

    // R3 overflow
    for (int i = 0; i < 17; i++) pushTx(8'h80 + 8'(i));
    readChk("R3 tx count full", 3'd5, 8'h10);
    readChk("R3 overflow bit", 3'd3, 8'h01);
    drainTx(40);
    compared++;
    if (txExp.size() != 0) begin
      mismatched++;
      $display("FAIL R3 tx leftover: actual %0d expected 0", txExp.size());
    end
    readChk("R3 tx drained", 3'd5, 8'h40);
    regWrite(3'd3, 8'h40);
    readChk("R4 clear wipes flags", 3'd3, 8'h00);
    readChk("R4 clear wipes tx flag", 3'd5, 8'h00);

    // R7/R8/R9 receive, threshold 1 with last marker
    regWrite(3'd4, 8'h00);
    regWrite(3'd6, 8'h61);
    shiftIn(8'h5C, 1'b1);
    readChk("R8 rx flag and count", 3'd7, 8'h41);
    readChk("R8 done on last", 3'd3, 8'h02);
    readChk("R9 byteReady suppressed", 3'd1, 8'h00);
    @(negedge clk);
    chk("R10 irq on rx flag", {7'b0, irq}, 8'h01);
    readRx();
    readChk("R7 rx count after pop", 3'd7, 8'h40);
    regWrite(3'd7, 8'h40);
    regWrite(3'd3, 8'h02);

    regWrite(3'd6, 8'h00);
    shiftIn(8'h11, 1'b1); shiftIn(8'h22, 1'b1); shiftIn(8'h33, 1'b1);
    readChk("R9 byteReady plain", 3'd1, 8'h01);
    readChk("R7 rx count 3", 3'd7, 8'h03);
    readRx(); readRx(); readRx();
    readChk("R7 rx count 0", 3'd7, 8'h00);
    readChk("R9 byteReady empty", 3'd1, 8'h00);

    regWrite(3'd6, 8'h50);
    for (int i = 0; i < 16; i++) shiftIn(8'hC0 + 8'(i), 1'b1);
    readChk("R9 byteReady at 16", 3'd1, 8'h01);
    readChk("R8 rx flag at 16", 3'd7, 8'h50);
    readChk("R8 no done without last", 3'd3, 8'h00);
    shiftIn(8'hEE, 1'b0);
    readChk("R7 rx full holds", 3'd7, 8'h50);
    readChk("R7 rx overflow bit", 3'd3, 8'h01);
    readRx(); readRx();
    readChk("R7 rx count 14", 3'd7, 8'h4E);

    // R10 disable drops irq, R11 bank 0 view, R2 ignore while off
    @(negedge clk);
    chk("R10 irq before disable", {7'b0, irq}, 8'h01);
    regWrite(3'd2, 8'h00);
    regWrite(3'd3, 8'h00);
    rxExp.delete();
    @(negedge clk);
    chk("R10 irq after disable", {7'b0, irq}, 8'h00);
    chk("R2 byteReady off", {7'b0, byteReady}, 8'h00);
    regWrite(3'd4, 8'h5F);
    readChk("R11 bank0 addr4", 3'd4, 8'h00);
    readChk("R11 bank0 addr7", 3'd7, 8'h00);
    regWrite(3'd0, 8'h77);
    regWrite(3'd2, 8'h80);
    readChk("R2 tx count off", 3'd5, 8'h00);
    readChk("R11 tx ctl untouched", 3'd4, 8'h00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule